// File: doc/BRIEF.md
# SDRAM Burst Command Sequencer

This block turns host read and write requests of 1 to 32 bytes into SDRAM command sequences on a data path that is 32 bits wide and can be set to 8, 16 or 32 bits. Each request opens a row with ACTIVE and issues one READ or WRITE. The access always runs as a fixed-length burst and closes with a single-bank PRECHARGE. The burst length depends on the port width. Beats the host does not need are hidden by holding the byte-lane data-mask lines high. Within a partly used beat, the lanes past the last requested byte are also masked.

The sequencer can end a burst early. If another host request, a refresh or a mode reload is waiting when the last needed beat finishes, it precharges at once and moves on. After reset, and each time `mode_load` is pulsed, it issues PRECHARGE-all and then a MODE-SET command that carries the CAS latency and the burst-length code on the address lines. A refresh timer raises a refresh request every prescale × interval cycles. The sequencer serves that request ahead of any host request, but only once the burst in progress has ended. It serves it as PRECHARGE-all, then AUTO-REFRESH, then a fixed recovery wait.

Top module: `sdram_burst_seq`

## Requirements
- R1: While reset is asserted and in the cycle after reset is released, the command is PRECHARGE with address bit 10 high. MODE-SET follows in the next cycle. The same two-command sequence follows a `mode_load` pulse. During MODE-SET the address carries the burst-length code in bits 2:0 (3'b011 for 8 beats, 3'b010 for 4 beats), 0 in bit 3, and the CAS latency in bits 6:4.
- R2: Commands are encoded on {ras_n, cas_n, we_n} as follows: ACTIVE 011, READ 101, WRITE 100, PRECHARGE 010, AUTO-REFRESH 001, MODE-SET 000 and NOP 111. `sd_cs_n` is low for every command and high for NOP.
- R3: `cfg_port_w` selects the port width: 0 for 8-bit, 1 for 16-bit, 2 for 32-bit. The burst is 4 beats for a 16-bit port and 8 beats otherwise. With no other work waiting, the burst runs its full length before PRECHARGE is issued.
- R4: The number of needed beats is ceil(bytes / port bytes), capped at the burst length. `req_ack` is high in the cycle of the last needed beat.
- R5: A write drives beat k in the cycle k after the WRITE command, with `dq_drive` high. On needed beats, `sd_dqm[j]` is low only for the lanes j that carry requested bytes. Lanes are filled from lane 0 upward, and only the lanes inside the port width are used. On beats that are not needed, all mask bits are high.
- R6: A read captures beat k CAS-latency + k cycles after the READ command, with `dq_capture` high and the same lane mask rule as R5. Beats that are not needed have all mask bits high and are not captured.
- R7: If a request, a refresh or a mode reload is waiting in the cycle of the last needed beat, PRECHARGE is issued in the very next cycle, which ends the burst.
- R8: Consecutive AUTO-REFRESH commands issued from idle are exactly `cfg_prescale` × `cfg_interval` cycles apart.
- R9: AUTO-REFRESH never falls inside a burst. It always comes in the cycle right after a PRECHARGE with address bit 10 high. Refresh is served even while host requests are waiting all the time.
- R10: ACTIVE carries the request row on `sd_addr` and the bank on `sd_ba`. READ or WRITE follows in the next cycle, with the column on `sd_addr`, address bit 10 low and the same bank. The closing PRECHARGE has bit 10 low and names the same bank.
- R11: `req_ack` is a one-cycle pulse for each transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_port_w | input | 2 | Port width select: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit |
| cfg_cas_lat | input | 2 | CAS latency in cycles |
| cfg_prescale | input | 8 | Refresh prescaler, in cycles per tick |
| cfg_interval | input | 8 | Refresh interval, in ticks |
| mode_load | input | 1 | Pulse that re-issues PRECHARGE-all and MODE-SET |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Request address as {bank, row, column} |
| req_bytes | input | 6 | Transfer size, 1 to 32 bytes |
| req_ready | output | 1 | Request is taken on the edge where it is high together with `req_valid` |
| req_ack | output | 1 | Last needed beat of the transaction |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 13 | Row, column or mode address |
| sd_dqm | output | 4 | Byte-lane data mask; high means masked |
| dq_drive | output | 1 | Write data beat is driven in this cycle |
| dq_capture | output | 1 | Read data beat is captured in this cycle |

## Verification
Reads and writes are tried at all three port widths, with both CAS latencies and with random sizes. Directed sizes add 1 byte, exactly one beat, one byte more than a beat, 31 and 32 bytes. Together these separate the correct beat count and partial-lane mask from off-by-one errors and from a cap that is missing. The bench runs back-to-back requests alongside isolated ones, so an early-terminated burst is seen next to a full-length one. The refresh tests use an idle period, which shows that the spacing is the prescale × interval product, and a saturating request stream, which shows that refresh waits for the end of the burst yet still wins against waiting host requests.

// File: rtl/sdram_seq_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the SDRAM burst sequencer.
// Assumes: commands are {ras_n, cas_n, we_n}; chip select is derived separately.
package sdram_seq_pkg;
    typedef enum logic [2:0] {
        CMD_MRS = 3'b000,
        CMD_REF = 3'b001,
        CMD_PRE = 3'b010,
        CMD_ACT = 3'b011,
        CMD_WR  = 3'b100,
        CMD_RD  = 3'b101,
        CMD_NOP = 3'b111
    } sd_cmd_e;

    typedef enum logic [3:0] {
        ST_INIT_PRE, ST_MRS, ST_IDLE, ST_ACT, ST_XFER,
        ST_PRE, ST_REF_PRE, ST_REF, ST_REF_WAIT
    } seq_state_e;

    localparam logic [1:0] PW_8  = 2'd0;
    localparam logic [1:0] PW_16 = 2'd1;
endpackage

// File: rtl/sdram_refresh_timer.sv
`timescale 1ns/1ps
// Refresh interval timer: a prescaler produces a tick every cfg_prescale
// cycles, and every cfg_interval ticks a refresh request is raised.
// The request is held until the sequencer acknowledges it.
// Assumes: a zero value in either setting behaves as one.
module sdram_refresh_timer #(
    parameter int PS_W  = 8,
    parameter int INT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PS_W-1:0]  cfg_prescale,
    input  logic [INT_W-1:0] cfg_interval,
    input  logic             ref_ack,
    output logic             ref_due
);
    logic [PS_W-1:0]  ps_cnt, ps_last;
    logic [INT_W-1:0] iv_cnt, iv_last;
    logic             tick, fire;

    // Terminal counts and period events
    always_comb begin
        ps_last = (cfg_prescale == '0) ? '0 : cfg_prescale - 1'b1;
        iv_last = (cfg_interval == '0) ? '0 : cfg_interval - 1'b1;
        tick    = (ps_cnt >= ps_last);
        fire    = tick && (iv_cnt >= iv_last);
    end

    // Prescaler counter
    always_ff @(posedge clk) begin
        if (!rst_n)    ps_cnt <= '0;
        else if (tick) ps_cnt <= '0;
        else           ps_cnt <= ps_cnt + 1'b1;
    end

    // Interval counter, advanced by prescaler ticks
    always_ff @(posedge clk) begin
        if (!rst_n)    iv_cnt <= '0;
        else if (fire) iv_cnt <= '0;
        else if (tick) iv_cnt <= iv_cnt + 1'b1;
    end

    // Sticky refresh request
    always_ff @(posedge clk) begin
        if (!rst_n)       ref_due <= 1'b0;
        else if (fire)    ref_due <= 1'b1;
        else if (ref_ack) ref_due <= 1'b0;
    end

    // R8
    ref_due_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_due && !ref_ack) |=> ref_due);
endmodule

// File: rtl/sdram_lane_mask.sv
`timescale 1ns/1ps
// Beat planner: from the port width and transfer size, works out the burst
// length, how many beats are needed and which byte lanes of a given beat
// are unused (mask bit high).
// Assumes: lanes fill from lane 0 upward; the lanes above the port width are always masked.
module sdram_lane_mask
    import sdram_seq_pkg::*;
#(
    parameter int LANES   = 4,
    parameter int BYTES_W = 6,
    parameter int BEAT_W  = 4
) (
    input  logic [1:0]         port_w,
    input  logic [BYTES_W-1:0] xfer_bytes,
    input  logic [BEAT_W-1:0]  beat,
    output logic [BEAT_W-1:0]  burst_len,
    output logic [BEAT_W-1:0]  need_beats,
    output logic [LANES-1:0]   lane_off
);
    localparam int SUM_W = BYTES_W + BEAT_W + 2;
    logic [1:0]       shift;
    logic [SUM_W-1:0] pb, bytes_x, need_raw, remain, valid;

    // Beat count and per-beat valid byte count
    always_comb begin
        shift      = (port_w == PW_8) ? 2'd0 : (port_w == PW_16) ? 2'd1 : 2'd2;
        pb         = SUM_W'(1) << shift;
        burst_len  = (port_w == PW_16) ? BEAT_W'(4) : BEAT_W'(8);
        bytes_x    = SUM_W'(xfer_bytes);
        need_raw   = (bytes_x + pb - 1'b1) >> shift;
        if (need_raw == '0)                      need_beats = BEAT_W'(1);
        else if (need_raw > SUM_W'(burst_len))   need_beats = burst_len;
        else                                     need_beats = BEAT_W'(need_raw);
        remain     = bytes_x - (SUM_W'(beat) << shift);
        valid      = (remain >= pb) ? pb : remain;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_off[g] = !(SUM_W'(g) < valid);
    end
endmodule

// File: rtl/sdram_burst_seq.sv
`timescale 1ns/1ps
// SDRAM burst command sequencer. Runs initialisation and mode reloads
// (PRECHARGE-all, MODE-SET), host accesses (ACTIVE, READ/WRITE, full burst
// with masking and early end, PRECHARGE) and refresh (PRECHARGE-all,
// AUTO-REFRESH, recovery wait).
// Assumes: a one-cycle row-to-column delay; every access closes its row;
// COL_W <= 10 and ROW_W > 10, so address bit 10 serves as the all-banks flag.
module sdram_burst_seq
    import sdram_seq_pkg::*;
#(
    parameter int BANK_W     = 2,
    parameter int ROW_W      = 13,
    parameter int COL_W      = 9,
    parameter int DQ_W       = 32,
    parameter int PS_W       = 8,
    parameter int INT_W      = 8,
    parameter int REF_CYCLES = 4,
    localparam int REQ_AW    = BANK_W + ROW_W + COL_W,
    localparam int LANES     = DQ_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_port_w,
    input  logic [1:0]        cfg_cas_lat,
    input  logic [PS_W-1:0]   cfg_prescale,
    input  logic [INT_W-1:0]  cfg_interval,
    input  logic              mode_load,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [REQ_AW-1:0] req_addr,
    input  logic [5:0]        req_bytes,
    output logic              req_ready,
    output logic              req_ack,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ROW_W-1:0]  sd_addr,
    output logic [LANES-1:0]  sd_dqm,
    output logic              dq_drive,
    output logic              dq_capture
);
    localparam int A10    = 10;
    localparam int BEAT_W = 4;
    localparam int RW_W   = $clog2(REF_CYCLES + 1);

    seq_state_e         state;
    sd_cmd_e            cur_cmd;
    logic               ref_due, ref_ack, mode_pend;
    logic               t_write;
    logic [BANK_W-1:0]  t_bank;
    logic [ROW_W-1:0]   t_row;
    logic [COL_W-1:0]   t_col;
    logic [5:0]         t_bytes;
    logic [BEAT_W-1:0]  dcyc, off, beat, bl, need, last_need, full_last;
    logic [RW_W-1:0]    wcnt;
    logic [LANES-1:0]   lane_off;
    logic               data_cyc, beat_need, waiting;

    sdram_refresh_timer #(.PS_W(PS_W), .INT_W(INT_W)) u_ref (
        .clk(clk), .rst_n(rst_n), .cfg_prescale(cfg_prescale),
        .cfg_interval(cfg_interval), .ref_ack(ref_ack), .ref_due(ref_due));

    sdram_lane_mask #(.LANES(LANES), .BYTES_W(6), .BEAT_W(BEAT_W)) u_mask (
        .port_w(cfg_port_w), .xfer_bytes(t_bytes), .beat(beat),
        .burst_len(bl), .need_beats(need), .lane_off(lane_off));

    // Burst timing points relative to the READ/WRITE cycle
    always_comb begin
        off       = t_write ? '0 : BEAT_W'(cfg_cas_lat);
        data_cyc  = (dcyc >= off);
        beat      = dcyc - off;
        beat_need = data_cyc && (beat < need);
        last_need = off + need - 1'b1;
        full_last = off + bl - 1'b1;
        waiting   = req_valid || ref_due || mode_pend;
        req_ready = (state == ST_IDLE) && !ref_due && !mode_pend;
        ref_ack   = (state == ST_REF);
    end

    // Pending mode reload flag
    always_ff @(posedge clk) begin
        if (!rst_n)              mode_pend <= 1'b0;
        else if (mode_load)      mode_pend <= 1'b1;
        else if (state == ST_MRS) mode_pend <= 1'b0;
    end

    // Main sequencing state machine and request latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_INIT_PRE;
            dcyc    <= '0;
            wcnt    <= '0;
            t_write <= 1'b0;
            t_bank  <= '0;
            t_row   <= '0;
            t_col   <= '0;
            t_bytes <= 6'd1;
        end else begin
            case (state)
                ST_INIT_PRE: state <= ST_MRS;
                ST_MRS:      state <= ST_IDLE;
                ST_IDLE: begin
                    if (ref_due)        state <= ST_REF_PRE;
                    else if (mode_pend) state <= ST_INIT_PRE;
                    else if (req_valid) begin
                        state   <= ST_ACT;
                        t_write <= req_write;
                        t_bank  <= req_addr[REQ_AW-1 -: BANK_W];
                        t_row   <= req_addr[COL_W +: ROW_W];
                        t_col   <= req_addr[COL_W-1:0];
                        t_bytes <= req_bytes;
                    end
                end
                ST_ACT: begin
                    state <= ST_XFER;
                    dcyc  <= '0;
                end
                ST_XFER: begin
                    if ((dcyc == last_need && waiting) || dcyc == full_last)
                        state <= ST_PRE;
                    else
                        dcyc <= dcyc + 1'b1;
                end
                ST_PRE:     state <= ST_IDLE;
                ST_REF_PRE: state <= ST_REF;
                ST_REF: begin
                    state <= ST_REF_WAIT;
                    wcnt  <= RW_W'(REF_CYCLES - 1);
                end
                ST_REF_WAIT: begin
                    if (wcnt == '0) state <= ST_IDLE;
                    else            wcnt  <= wcnt - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Command, address and data-lane outputs for the current state
    always_comb begin
        cur_cmd    = CMD_NOP;
        sd_addr    = '0;
        sd_ba      = t_bank;
        sd_dqm     = '1;
        dq_drive   = 1'b0;
        dq_capture = 1'b0;
        req_ack    = 1'b0;
        case (state)
            ST_INIT_PRE, ST_REF_PRE: begin
                cur_cmd      = CMD_PRE;
                sd_addr[A10] = 1'b1;
            end
            ST_MRS: begin
                cur_cmd      = CMD_MRS;
                sd_addr[2:0] = (bl == BEAT_W'(8)) ? 3'b011 : 3'b010;
                sd_addr[6:4] = {1'b0, cfg_cas_lat};
            end
            ST_ACT: begin
                cur_cmd = CMD_ACT;
                sd_addr = t_row;
            end
            ST_XFER: begin
                if (dcyc == '0) begin
                    cur_cmd = t_write ? CMD_WR : CMD_RD;
                    sd_addr = ROW_W'(t_col);
                end
                if (beat_need) sd_dqm = lane_off;
                dq_drive   = beat_need && t_write;
                dq_capture = beat_need && !t_write;
                req_ack    = (dcyc == last_need);
            end
            ST_PRE: cur_cmd = CMD_PRE;
            ST_REF: cur_cmd = CMD_REF;
            default: cur_cmd = CMD_NOP;
        endcase
        {sd_ras_n, sd_cas_n, sd_we_n} = cur_cmd;
        sd_cs_n = (cur_cmd == CMD_NOP);
    end

    // R11
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);
    // R10
    act_then_rw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_cmd == CMD_ACT) |=> (cur_cmd == CMD_RD || cur_cmd == CMD_WR));
    // R9
    ref_after_pall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_cmd == CMD_REF) |-> $past(cur_cmd == CMD_PRE && sd_addr[A10]));
    // R9
    ref_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_cmd == CMD_PRE && !sd_addr[A10] && ref_due)
        |=> ##1 (cur_cmd == CMD_PRE && sd_addr[A10]));
    // R5
    dqm_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dq_drive || dq_capture) |-> (&sd_dqm));
endmodule

// File: tb/sdram_burst_seq_test.sv
`timescale 1ns/1ps
module sdram_burst_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_port_w = 2'd2;
    logic [1:0]  cfg_cas_lat = 2'd2;
    logic [7:0]  cfg_prescale = 8'd255;
    logic [7:0]  cfg_interval = 8'd255;
    logic        mode_load = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic [5:0]  req_bytes = 6'd1;
    logic        req_ready, req_ack, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [12:0] sd_addr;
    logic [3:0]  sd_dqm;
    logic        dq_drive, dq_capture;
    logic [2:0]  cmd;
    int          total = 0, passed = 0;
    logic        n_w;
    logic [23:0] n_addr;
    logic [5:0]  n_bytes;

    always #2 clk = ~clk;
    assign cmd = {sd_ras_n, sd_cas_n, sd_we_n};

    sdram_burst_seq uut (
        .clk(clk), .rst_n(rst_n), .cfg_port_w(cfg_port_w), .cfg_cas_lat(cfg_cas_lat),
        .cfg_prescale(cfg_prescale), .cfg_interval(cfg_interval), .mode_load(mode_load),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_bytes(req_bytes), .req_ready(req_ready), .req_ack(req_ack),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm),
        .dq_drive(dq_drive), .dq_capture(dq_capture));

    task automatic summary();
        $display("  %0d/%0d checks passed", passed, total);
    endtask

    task automatic chk(input string rq, input int act, input int exp);
        total++;
        if (act == exp) passed++;
        else $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    function automatic int exp_bl(input logic [1:0] pw);
        return (pw == 2'd1) ? 4 : 8;
    endfunction
    function automatic int exp_pb(input logic [1:0] pw);
        return (pw == 2'd0) ? 1 : (pw == 2'd1) ? 2 : 4;
    endfunction
    function automatic int exp_need(input int bytes, input logic [1:0] pw);
        int n = (bytes + exp_pb(pw) - 1) / exp_pb(pw);
        return (n > exp_bl(pw)) ? exp_bl(pw) : n;
    endfunction
    function automatic int exp_mask(input int bytes, input logic [1:0] pw, input int b);
        int rem = bytes - b * exp_pb(pw);
        int v = (rem >= exp_pb(pw)) ? exp_pb(pw) : rem;
        int m = 0;
        for (int j = 0; j < 4; j++) if (j >= v) m |= (1 << j);
        return m;
    endfunction

    // Reload mode and check PRECHARGE-all then MODE-SET (R1)
    task automatic reconfig(input logic [1:0] pw, input logic [1:0] cl);
        int found = 0;
        cfg_port_w = pw; cfg_cas_lat = cl; mode_load = 1'b1;
        step(); mode_load = 1'b0;
        for (int k = 0; k < 10; k++) begin
            if (cmd == 3'b010 && sd_addr[10]) begin found = 1; break; end
            step();
        end
        chk("R1 pre-all before mode", found, 1);
        step();
        chk("R1 mode cmd", cmd, 3'b000);
        chk("R1 mode BL code", sd_addr[2:0], (pw == 2'd1) ? 3'b010 : 3'b011);
        chk("R1 mode CL", sd_addr[6:4], cl);
        step();
        chk("R2 idle nop deselect", {sd_cs_n, cmd}, 4'b1111);
    endtask

    // One transaction with cycle-by-cycle checks
    task automatic run_txn(input logic w, input logic [23:0] a, input int bytes, input bit chain);
        int off, need, bl, lastn, fulll, endd, b;
        req_valid = 1'b1; req_write = w; req_addr = a; req_bytes = 6'(bytes);
        for (int k = 0; k < 30; k++) begin
            if (req_ready) break;
            step();
        end
        step();
        chk("R10 ACTIVE cmd", cmd, 3'b011);
        chk("R2 cs on ACTIVE", sd_cs_n, 0);
        chk("R10 row", sd_addr, a[21:9]);
        chk("R10 bank", sd_ba, a[23:22]);
        if (chain) begin req_write = n_w; req_addr = n_addr; req_bytes = n_bytes; end
        else req_valid = 1'b0;
        off = w ? 0 : cfg_cas_lat; need = exp_need(bytes, cfg_port_w);
        bl = exp_bl(cfg_port_w); lastn = off + need - 1; fulll = off + bl - 1;
        endd = chain ? lastn : fulll;
        for (int d = 0; d <= endd; d++) begin
            step();
            if (d == 0) begin
                chk("R10 rw cmd", cmd, w ? 3'b100 : 3'b101);
                chk("R10 column a10 low", sd_addr, {4'b0, a[8:0]});
            end else chk("R3 nop in burst", cmd, 3'b111);
            chk((d == lastn) ? "R4" : "R11", req_ack, (d == lastn) ? 1 : 0);
            b = d - off;
            if (d >= off && b < need) begin
                chk(w ? "R5 write mask" : "R6 read mask", sd_dqm, exp_mask(bytes, cfg_port_w, b));
                chk(w ? "R5 drive" : "R6 capture", w ? dq_drive : dq_capture, 1);
            end else begin
                chk(w ? "R5 unused mask" : "R6 unused mask", sd_dqm, 15);
                chk("R6 no data", {dq_drive, dq_capture}, 0);
            end
        end
        step();
        chk(chain ? "R7 early precharge" : "R3 full burst precharge", cmd, 3'b010);
        chk("R10 precharge a10 low bank", {sd_addr[10], sd_ba}, {1'b0, a[23:22]});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic        cw;
        logic [23:0] ca;
        int          cb, nref, gap, tref, prev_pall, in_burst, acks;
        void'($urandom(32'd20240517));
        // Reset state (R1)
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset pre-all", {cmd, sd_addr[10]}, 4'b0101);
        chk("R4 reset ack", req_ack, 0);
        chk("R5 reset mask", sd_dqm, 15);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R1 first cycle pre-all", {cmd, sd_addr[10]}, 4'b0101);
        step();
        chk("R1 mode after reset", cmd, 3'b000);
        chk("R1 mode BL8", sd_addr[6:0], 7'b0100011);
        step();
        chk("R2 idle", {sd_cs_n, cmd}, 4'b1111);

        for (int pw = 0; pw < 3; pw++) begin
            reconfig(2'(pw), (pw == 1) ? 2'd3 : 2'd2);
            cw = 1'(pw); ca = 24'($urandom); cb = 1;
            for (int i = 0; i < 60; i++) begin
                n_w = 1'($urandom); n_addr = 24'($urandom);
                case (i)
                    0: n_bytes = 6'(exp_pb(2'(pw)));
                    1: n_bytes = 6'(exp_pb(2'(pw)) + 1);
                    2: n_bytes = 6'd32;
                    3: n_bytes = 6'd31;
                    4: n_bytes = 6'd3;
                    default: n_bytes = 6'(1 + $urandom % 32);
                endcase
                run_txn(cw, ca, cb, (i != 59) && ($urandom % 2 == 1));
                cw = n_w; ca = n_addr; cb = int'(n_bytes);
            end
            req_valid = 1'b0;
            step(); step();
        end

        // Refresh spacing from idle (R8)
        cfg_prescale = 8'd3; cfg_interval = 8'd10;
        nref = 0; gap = 0; tref = 0;
        for (int t = 0; t < 400 && nref < 3; t++) begin
            step();
            if (cmd == 3'b001) begin
                nref++;
                if (nref == 3) gap = t - tref;
                tref = t;
            end
        end
        chk("R8 refresh spacing", gap, 30);

        // Refresh under saturating requests (R9, R7)
        cfg_prescale = 8'd1; cfg_interval = 8'd50;
        req_valid = 1'b1; req_write = 1'b1; req_bytes = 6'd4; req_addr = 24'h5a_1234;
        nref = 0; prev_pall = 0; in_burst = 0; acks = 0;
        for (int t = 0; t < 400; t++) begin
            step();
            if (req_ack) acks++;
            if (cmd == 3'b001) begin
                nref++;
                chk("R9 refresh outside burst", in_burst, 0);
                chk("R9 pre-all before refresh", prev_pall, 1);
            end
            if (cmd == 3'b011) in_burst = 1;
            if (cmd == 3'b010 && !sd_addr[10]) in_burst = 0;
            prev_pall = (cmd == 3'b010 && sd_addr[10]) ? 1 : 0;
        end
        req_valid = 1'b0;
        chk("R9 refresh wins over requests", (nref >= 6) ? 1 : 0, 1);
        chk("R7 stream progresses", (acks > 20) ? 1 : 0, 1);
        repeat (20) step();
        summary();
        $finish;
    end
endmodule